// File: doc/BRIEF.md
# Fetch-Linked DRAM Row Refresh Generator

This block produces the row addresses that keep a dynamic memory alive on a small processor bus. An internal row register moves forward by one each time the processor completes an opcode fetch. In the bus cycle that follows such a fetch, the block raises a refresh strobe, tells every other bus master to let go of the address bus, and places the row register on the low address bits. Every memory device on the bus can then refresh that row at the same time, because the data bus is not used.

A sequencer with three states controls the timing. **IDLE** is the resting state. **DUMMY_FETCH** is a stand-in opcode fetch that the block makes up for itself while the processor is halted. **REFRESH** is the one-cycle refresh slot. The transitions are:
- *fetch-accept*: IDLE to REFRESH, when a fetch is seen and there is no halt. The row register steps.
- *halt-enter*: IDLE to DUMMY_FETCH, when halt is high.
- *dummy-complete*: DUMMY_FETCH to REFRESH, always. The row register steps.
- *refresh-resume-halt*: REFRESH to DUMMY_FETCH, when halt is still high.
- *refresh-end*: REFRESH to IDLE, when halt is low.
- *idle-hold*: IDLE to IDLE, when there is neither fetch nor halt.

While halted, refresh continues in whole fetch-plus-refresh steps. Software can overwrite the row register at any time, and counting continues from the written value.

Top module: `fetch_refresh_gen`

## Requirements
- R1: When reset is asserted (asynchronous, active low), the row register is cleared to 0, the sequencer returns to IDLE, and the strobe, the drive enable and the address are all held low.
- R2: Each accepted fetch adds one to row bits 6:0, and these bits wrap from 127 to 0.
- R3: The refresh slot is exactly the one cycle after an accepted fetch. In that cycle the strobe and the drive enable are both 1, and the next cycle is never a second refresh slot.
- R4: In the refresh slot, address bits 6:0 carry the row value after the step, bit 7 carries row bit 7, and bits 15:8 are 0.
- R5: While halt is high, the block alternates one DUMMY_FETCH cycle (strobe low) with one REFRESH cycle. The row steps once per pair.
- R6: A write loads all 8 row bits on the next edge. A write takes priority over a step on the same edge. Later steps count from the written value.
- R7: Outside the refresh slot, the strobe and the drive enable are 0 and the address output is all zeros.
- R8: A step never changes row bit 7. Only a write or a reset changes bit 7.
- R9: A fetch indication seen during the refresh slot is ignored. It causes no step and no extra refresh slot.
- R10: In IDLE, halt takes priority over fetch. A fetch and a halt seen together produce a dummy fetch and only one step. If halt drops during DUMMY_FETCH, the refresh slot that follows still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_cyc | input | 1 | High during an opcode fetch bus cycle |
| halt_req | input | 1 | Processor is halted; the block makes dummy fetches |
| row_wr_en | input | 1 | Software write strobe for the row register |
| row_wr_data | input | 8 | Value loaded on a software write |
| rfsh_strobe | output | 1 | High during the refresh slot |
| addr_drive_en | output | 1 | High when the block owns the address bus |
| addr_out | output | 16 | Refresh address; zero outside the refresh slot |

## Verification
The properties assume that the fetch indication comes from the processor's own bus sequencing. It therefore shows up as a one-cycle indication in a free bus cycle, and a write and a step may coincide only in the ways R6 covers. The bench drives every input on the falling clock edge. It keeps fetch pulses to single cycles, except in the one test that deliberately holds fetch high into the refresh slot to exercise R9. It starts each test by writing a known row value, so that expected addresses do not depend on history.

// File: rtl/rfgen_pkg.sv
package rfgen_pkg;

    // Sequencer states of the refresh generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DUMMY = 2'd1,
        ST_RFSH  = 2'd2
    } rf_state_e;

    // Operation applied to the row register at the next edge
    typedef enum logic [1:0] {
        ROW_HOLD  = 2'd0,
        ROW_STEP  = 2'd1,
        ROW_WRITE = 2'd2
    } row_op_e;

endpackage

// File: rtl/rfgen_row.sv
module rfgen_row
    import rfgen_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] row_q
);

    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    logic [REG_W-1:0] row_inc;
    row_op_e          op;

    // Increment confined to the low ROW_W bits; anything above is kept
    generate
        if (REG_W > ROW_W) begin : g_keep_hi
            assign row_inc = {row_q[REG_W-1:ROW_W], row_q[ROW_W-1:0] + ROW_ONE};
        end else begin : g_flat
            assign row_inc = row_q + REG_W'(1);
        end
    endgenerate

    // Write outranks step
    always_comb begin
        if (wr_en)      op = ROW_WRITE;
        else if (step)  op = ROW_STEP;
        else            op = ROW_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            unique case (op)
                ROW_WRITE: row_q <= wr_data;
                ROW_STEP:  row_q <= row_inc;
                ROW_HOLD:  row_q <= row_q;
                default:   row_q <= row_q;
            endcase
        end
    end

endmodule

// File: rtl/rfgen_seq.sv
module rfgen_seq
    import rfgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fetch,
    input  logic      halt,
    output rf_state_e state,
    output logic      step,
    output logic      rfsh_on
);

    rf_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (halt)       nxt = ST_DUMMY;   // halt-enter
                else if (fetch) nxt = ST_RFSH;    // fetch-accept
                else            nxt = ST_IDLE;    // idle-hold
            end
            ST_DUMMY: nxt = ST_RFSH;              // dummy-complete
            ST_RFSH: begin
                if (halt) nxt = ST_DUMMY;         // refresh-resume-halt
                else      nxt = ST_IDLE;          // refresh-end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        step    = 1'b0;
        rfsh_on = 1'b0;
        unique case (state)
            ST_IDLE:  step = fetch && !halt;
            ST_DUMMY: step = 1'b1;
            ST_RFSH:  rfsh_on = 1'b1;
            default: begin
                step    = 1'b0;
                rfsh_on = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rfgen_addr.sv
module rfgen_addr #(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              drive,
    input  logic [REG_W-1:0]  row,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - REG_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = drive ? {{PAD_W{1'b0}}, row} : '0;
        end else begin : g_exact
            assign addr = drive ? row[ADDR_W-1:0] : '0;
        end
    endgenerate

endmodule

// File: rtl/fetch_refresh_gen.sv
module fetch_refresh_gen
    import rfgen_pkg::*;
#(
    parameter int ROW_W  = 7,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_cyc,
    input  logic              halt_req,
    input  logic              row_wr_en,
    input  logic [REG_W-1:0]  row_wr_data,
    output logic              rfsh_strobe,
    output logic              addr_drive_en,
    output logic [ADDR_W-1:0] addr_out
);

    rf_state_e        cur_state;
    logic             step;
    logic             rfsh_on;
    logic [REG_W-1:0] row_q;

    rfgen_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetch   (fetch_cyc),
        .halt    (halt_req),
        .state   (cur_state),
        .step    (step),
        .rfsh_on (rfsh_on)
    );

    rfgen_row #(.ROW_W(ROW_W), .REG_W(REG_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .wr_en   (row_wr_en),
        .wr_data (row_wr_data),
        .row_q   (row_q)
    );

    rfgen_addr #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_addr (
        .drive (rfsh_on),
        .row   (row_q),
        .addr  (addr_out)
    );

    assign rfsh_strobe   = rfsh_on;
    assign addr_drive_en = rfsh_on;

endmodule

// File: rtl/fetch_refresh_gen_chk.sv
module fetch_refresh_gen_chk
    import rfgen_pkg::*;
#(
    parameter int ROW_W  = 7,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_cyc,
    input logic              halt_req,
    input logic              row_wr_en,
    input logic [REG_W-1:0]  row_wr_data,
    input logic              rfsh_strobe,
    input logic              addr_drive_en,
    input logic [ADDR_W-1:0] addr_out,
    input rf_state_e         cur_state,
    input logic [REG_W-1:0]  row_q
);

    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (row_q == '0 && !rfsh_strobe && addr_out == '0));

    assert_fetch_gives_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && fetch_cyc && !halt_req) |=> (rfsh_strobe && addr_drive_en));

    assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_strobe |=> !rfsh_strobe);

    assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && fetch_cyc && !halt_req && !row_wr_en)
        |=> (addr_out[ROW_W-1:0] == $past(row_q[ROW_W-1:0]) + ONE));

    assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_strobe |-> (!addr_drive_en && addr_out == '0));

    assert_dummy_then_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_DUMMY) |=> rfsh_strobe);

    assert_halt_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && halt_req) |=> !rfsh_strobe);

    assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_wr_en |=> (row_q == $past(row_wr_data)));

    assert_top_bit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !row_wr_en |=> (row_q[REG_W-1] == $past(row_q[REG_W-1])));

    assert_refresh_ignores_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_strobe && !row_wr_en) |=> $stable(row_q));

endmodule

bind fetch_refresh_gen fetch_refresh_gen_chk #(
    .ROW_W(ROW_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_cyc     (fetch_cyc),
    .halt_req      (halt_req),
    .row_wr_en     (row_wr_en),
    .row_wr_data   (row_wr_data),
    .rfsh_strobe   (rfsh_strobe),
    .addr_drive_en (addr_drive_en),
    .addr_out      (addr_out),
    .cur_state     (cur_state),
    .row_q         (row_q)
);

// File: tb/sim_fetch_refresh_gen.sv
`timescale 1ns/1ps
module sim_fetch_refresh_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_cyc = 1'b0;
    logic        halt_req = 1'b0;
    logic        row_wr_en = 1'b0;
    logic [7:0]  row_wr_data = '0;
    logic        rfsh_strobe;
    logic        addr_drive_en;
    logic [15:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_refresh_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_cyc     (fetch_cyc),
        .halt_req      (halt_req),
        .row_wr_en     (row_wr_en),
        .row_wr_data   (row_wr_data),
        .rfsh_strobe   (rfsh_strobe),
        .addr_drive_en (addr_drive_en),
        .addr_out      (addr_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bus(string req, logic exp_on, logic [15:0] exp_addr);
        checks++;
        if (rfsh_strobe !== exp_on || addr_drive_en !== exp_on || addr_out !== exp_addr) begin
            errors++;
            $display("FAIL %s: strobe=%b en=%b addr=%h expected strobe=%b en=%b addr=%h",
                     req, rfsh_strobe, addr_drive_en, addr_out, exp_on, exp_on, exp_addr);
        end
    endtask

    task automatic do_write(logic [7:0] v);
        row_wr_en = 1'b1;
        row_wr_data = v;
        tick();
        row_wr_en = 1'b0;
        check_bus("R7 after write", 1'b0, 16'h0000);
    endtask

    task automatic do_fetch(string req, logic [15:0] exp_addr);
        fetch_cyc = 1'b1;
        tick();
        fetch_cyc = 1'b0;
        check_bus(req, 1'b1, exp_addr);
        tick();
        check_bus("R7 after refresh", 1'b0, 16'h0000);
    endtask

    task automatic t_reset();
        check_bus("R1 reset outputs", 1'b0, 16'h0000);
        do_fetch("R1 first row after reset", 16'h0001);
        do_fetch("R2 second row", 16'h0002);
        do_write(8'h33);
        rst_n = 1'b0;
        tick();
        check_bus("R1 in reset", 1'b0, 16'h0000);
        rst_n = 1'b1;
        tick();
        do_fetch("R1 row cleared by reset", 16'h0001);
    endtask

    task automatic t_wrap();
        do_write(8'h7E);
        do_fetch("R2 step to 127", 16'h007F);
        do_fetch("R2 wrap 127 to 0", 16'h0000);
        do_write(8'hFE);
        do_fetch("R4 bit7 on address", 16'h00FF);
        do_fetch("R8 bit7 kept on wrap", 16'h0080);
    endtask

    task automatic t_write_prio();
        row_wr_en = 1'b1;
        row_wr_data = 8'h20;
        fetch_cyc = 1'b1;
        tick();
        row_wr_en = 1'b0;
        fetch_cyc = 1'b0;
        check_bus("R6 write beats step", 1'b1, 16'h0020);
        tick();
        check_bus("R7 after refresh", 1'b0, 16'h0000);
        do_fetch("R6 count resumes", 16'h0021);
    endtask

    task automatic t_fetch_in_refresh();
        do_write(8'h40);
        fetch_cyc = 1'b1;
        tick();
        check_bus("R3 refresh slot", 1'b1, 16'h0041);
        tick();
        fetch_cyc = 1'b0;
        check_bus("R9 no second slot", 1'b0, 16'h0000);
        do_fetch("R9 no extra step", 16'h0042);
    endtask

    task automatic t_halt();
        do_write(8'h10);
        halt_req = 1'b1;
        tick();
        check_bus("R5 dummy fetch", 1'b0, 16'h0000);
        tick();
        check_bus("R5 halt refresh 1", 1'b1, 16'h0011);
        tick();
        check_bus("R5 dummy fetch 2", 1'b0, 16'h0000);
        tick();
        check_bus("R5 halt refresh 2", 1'b1, 16'h0012);
        tick();
        check_bus("R5 dummy fetch 3", 1'b0, 16'h0000);
        halt_req = 1'b0;
        tick();
        check_bus("R10 dummy completes", 1'b1, 16'h0013);
        tick();
        check_bus("R5 back to idle", 1'b0, 16'h0000);
        tick();
        check_bus("R7 idle hold", 1'b0, 16'h0000);
    endtask

    task automatic t_halt_priority();
        do_write(8'h50);
        halt_req = 1'b1;
        fetch_cyc = 1'b1;
        tick();
        fetch_cyc = 1'b0;
        check_bus("R10 halt over fetch", 1'b0, 16'h0000);
        halt_req = 1'b0;
        tick();
        check_bus("R10 single step", 1'b1, 16'h0051);
        tick();
        check_bus("R7 after refresh", 1'b0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_write_prio();
        t_fetch_in_refresh();
        t_halt();
        t_halt_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule